// File: doc/BRIEF.md
# Four-Way Sub-Blocked Cache Tag Controller

This block holds the tags and the replacement state of a 4K-byte cache built as four sets of four ways. Each way stores one 256-byte block, split into four 64-byte sub-blocks. Every sub-block carries its own present flag and, when the dirty option is on, its own dirty flag. A tag can therefore match while the wanted sub-block has not yet been brought in. The data arrays, the fill engine and the external bus live outside this block.

A lookup is accepted while `req_ready` is high. One cycle later the block reports a hit, a sub-block miss (the tag matches but the sub-block is absent) or a full miss, together with the way that is used. On a full miss the least recently used way of the set is taken over. If that way holds dirty sub-blocks, the block first asks for a write-back of the old block and then asks for a fill of the one missing sub-block. The fill is for exactly one 64-byte sub-block.

The controller has three states. CT_IDLE accepts lookups. CT_WBACK waits for the write-back to finish. CT_FILL waits for the sub-block fill to finish. The transitions are: CT_IDLE to CT_WBACK on a full miss whose victim has dirty sub-blocks. CT_IDLE to CT_FILL on a sub-block miss or on a full miss with a clean victim. CT_WBACK to CT_FILL when `wb_done` is seen. CT_FILL to CT_IDLE when `fill_done` is seen. CT_IDLE stays in CT_IDLE on a hit or when there is no request.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `wb_req` and `fill_req` are 0. Every block is invalid. Each set's recency order is way 0 (most recent), then 1, 2 and 3, so way 3 is the first victim.
- R2: The address fields are: bits 31:10 tag, bits 9:8 set, bits 7:6 sub-block. A request accepted at a clock edge gives `rsp_valid`=1 after that edge, for one cycle, with `rsp_sub` equal to the sub-block field. When a valid way of the set holds the tag and its present flag for that sub-block is set, `rsp_hit`=1, `rsp_tag_match`=1, `rsp_way` is that way, and `req_ready` stays 1.
- R3: When the tag matches but the sub-block's present flag is clear, the response has `rsp_hit`=0, `rsp_tag_match`=1 and `rsp_way` set to the matched way. A fill is then requested for that same way. After the fill only that sub-block's present flag is set, and the other sub-blocks of the way keep their flags.
- R4: When no valid way of the set holds the tag, the response has `rsp_hit`=0, `rsp_tag_match`=0 and `rsp_way` set to the least recently used way. That way takes the new tag, and all of its present and dirty flags are cleared.
- R5: On a full miss whose victim is valid and has dirty sub-blocks, `wb_req` rises the cycle after the lookup. It stays high, with `wb_addr` = {old tag, set, 8'b0} and `wb_mask` bit i = dirty flag of sub-block i, until `wb_done` is seen. A clean victim goes straight to the fill.
- R6: While a fill is pending, `fill_req` is 1 with `fill_addr` = {tag, set, sub-block, 6'b0} and `fill_way` set to the way being filled, and `req_ready` is 0. After `fill_done` the controller returns to accepting lookups.
- R7: A write that hits, or a write whose fill completes, sets the dirty flag of that sub-block. The flag is observable through `wb_mask` when the block is later evicted.
- R8: Every accepted lookup makes the way it uses (hit, matched or victim) the most recent in its set. The ways that were more recent shift down by one place, and the ways below it keep their order. Each set's order is always a permutation of the four ways.
- R9: Lookups, fills and recency updates in one set leave the tags, flags and recency order of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Byte address of the lookup |
| req_write | input | 1 | Lookup is a write |
| req_ready | output | 1 | Controller accepts a lookup this cycle |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_hit | output | 1 | Tag and sub-block both present |
| rsp_tag_match | output | 1 | Tag matched a valid way |
| rsp_way | output | 2 | Way used by the lookup |
| rsp_sub | output | 2 | Sub-block addressed by the lookup |
| wb_req | output | 1 | Write-back of the evicted block requested |
| wb_addr | output | 32 | Base address of the evicted block |
| wb_mask | output | 4 | Dirty sub-blocks to write back |
| wb_done | input | 1 | Write-back finished |
| fill_req | output | 1 | Sub-block fill requested |
| fill_addr | output | 32 | Base address of the sub-block to fetch |
| fill_way | output | 2 | Way that receives the fill |
| fill_done | input | 1 | Fill finished |

## Verification
The assertions assume a well-behaved environment. A request is presented only while `req_ready` is high. `wb_done` is pulsed only while `wb_req` is high, and `fill_done` only while `fill_req` is high. Under these conditions the write-back and fill outputs hold steady until acknowledged, and each set's recency order stays a permutation. The stimulus raises `req_valid` only after seeing `req_ready` high, and its responder pulses each done signal for one cycle, a few cycles after the matching request appears. Directed sequences reach the sub-block miss, the dirty eviction and the LRU rotation. A random run then mixes reads and writes over a small tag pool in all four sets, so that hits, sub-block misses and evictions keep colliding.

// File: rtl/ctag_pkg.sv
`timescale 1ns/1ps
package ctag_pkg;
    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_WBACK = 2'd1,
        CT_FILL  = 2'd2
    } ctag_state_e;
endpackage

// File: rtl/cache_lru_order.sv
`timescale 1ns/1ps
// Per-set recency order: slot 0 most recent, slot WAYS-1 the victim.
module cache_lru_order #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [SET_W-1:0]            upd_set,
    input  logic [WAY_W-1:0]            upd_way,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAY_W-1:0]            victim_way,
    output logic [SETS*WAYS*WAY_W-1:0]  order_flat
);
    logic [WAY_W-1:0] ord_q    [SETS][WAYS];
    logic [WAY_W-1:0] next_ord [WAYS];
    logic [WAY_W-1:0] pos;

    always_comb begin
        pos = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ord_q[upd_set][i] == upd_way) pos = WAY_W'(i);
        end
        next_ord[0] = upd_way;
        for (int i = 1; i < WAYS; i++) begin
            next_ord[i] = (WAY_W'(i) <= pos) ? ord_q[upd_set][i-1] : ord_q[upd_set][i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int i = 0; i < WAYS; i++)
                    ord_q[s][i] <= WAY_W'(i);
        end else if (upd_en) begin
            for (int i = 0; i < WAYS; i++)
                ord_q[upd_set][i] <= next_ord[i];
        end
    end

    assign victim_way = ord_q[rd_set][WAYS-1];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar i = 0; i < WAYS; i++) begin : g_slot
            assign order_flat[(s*WAYS+i)*WAY_W +: WAY_W] = ord_q[s][i];
        end
    end
endmodule

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
// Tag, valid, per-sub-block present and (optionally) dirty storage.
module cache_tag_store #(
    parameter int SETS     = 4,
    parameter int WAYS     = 4,
    parameter int SUBS     = 4,
    parameter int TAG_W    = 22,
    parameter bit DIRTY_EN = 1'b1,
    parameter int SET_W    = $clog2(SETS),
    parameter int WAY_W    = $clog2(WAYS),
    parameter int SUB_W    = $clog2(SUBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [SUB_W-1:0]  lk_sub,
    output logic              lk_match,
    output logic [WAY_W-1:0]  lk_way,
    output logic              lk_present,
    input  logic [WAY_W-1:0]  rd_way,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [SUBS-1:0]   rd_dirty,
    input  logic              al_en,
    input  logic [WAY_W-1:0]  al_way,
    input  logic              mk_en,
    input  logic [SET_W-1:0]  mk_set,
    input  logic [WAY_W-1:0]  mk_way,
    input  logic [SUB_W-1:0]  mk_sub,
    input  logic              mk_present,
    input  logic              mk_dirty
);
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic             vld_q  [SETS][WAYS];
    logic [SUBS-1:0]  pres_q [SETS][WAYS];

    always_comb begin
        lk_match = 1'b0;
        lk_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
                lk_match = 1'b1;
                lk_way   = WAY_W'(w);
            end
        end
    end

    assign lk_present = pres_q[lk_set][lk_way][lk_sub];
    assign rd_valid   = vld_q[lk_set][rd_way];
    assign rd_tag     = tag_q[lk_set][rd_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    vld_q[s][w]  <= 1'b0;
                    pres_q[s][w] <= '0;
                end
        end else begin
            if (al_en) begin
                tag_q[lk_set][al_way]  <= lk_tag;
                vld_q[lk_set][al_way]  <= 1'b1;
                pres_q[lk_set][al_way] <= '0;
            end
            if (mk_en && mk_present)
                pres_q[mk_set][mk_way][mk_sub] <= 1'b1;
        end
    end

    if (DIRTY_EN) begin : g_dirty
        logic [SUBS-1:0] dty_q [SETS][WAYS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        dty_q[s][w] <= '0;
            end else begin
                if (al_en)
                    dty_q[lk_set][al_way] <= '0;
                if (mk_en && mk_dirty)
                    dty_q[mk_set][mk_way][mk_sub] <= 1'b1;
            end
        end
        assign rd_dirty = dty_q[lk_set][rd_way];
    end else begin : g_clean
        logic unused_dirty;
        assign unused_dirty = mk_dirty;
        assign rd_dirty     = '0;
    end
endmodule

// File: rtl/cache_tag_ctrl.sv
`timescale 1ns/1ps
module cache_tag_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int SUBS      = 4,
    parameter int SUB_BYTES = 64,
    parameter bit DIRTY_EN  = 1'b1,
    localparam int OFS_W    = $clog2(SUB_BYTES),
    localparam int SUB_W    = $clog2(SUBS),
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int BLK_LO   = OFS_W + SUB_W,
    localparam int TAG_LO   = BLK_LO + SET_W,
    localparam int TAG_W    = ADDR_W - TAG_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_tag_match,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [SUB_W-1:0]  rsp_sub,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SUBS-1:0]   wb_mask,
    input  logic              wb_done,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [WAY_W-1:0]  fill_way,
    input  logic              fill_done
);
    import ctag_pkg::*;

    ctag_state_e state_q, state_d;

    logic [SET_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [SUB_W-1:0] sub_i;
    logic             unused_ofs;
    assign set_i      = req_addr[TAG_LO-1:BLK_LO];
    assign tag_i      = req_addr[ADDR_W-1:TAG_LO];
    assign sub_i      = req_addr[BLK_LO-1:OFS_W];
    assign unused_ofs = ^req_addr[OFS_W-1:0];

    logic             lk_match, lk_present, rd_valid;
    logic [WAY_W-1:0] lk_way, victim, use_way;
    logic [TAG_W-1:0] rd_tag;
    logic [SUBS-1:0]  rd_dirty;
    logic [SETS*WAYS*WAY_W-1:0] lru_flat;

    logic accept, hit, sub_miss, full_miss, victim_dirty;
    assign accept       = req_valid && (state_q == CT_IDLE);
    assign hit          = accept && lk_match && lk_present;
    assign sub_miss     = accept && lk_match && !lk_present;
    assign full_miss    = accept && !lk_match;
    assign use_way      = lk_match ? lk_way : victim;
    assign victim_dirty = rd_valid && (|rd_dirty);

    logic              mk_en, mk_present, mk_dirty;
    logic [SET_W-1:0]  mk_set;
    logic [WAY_W-1:0]  mk_way;
    logic [SUB_W-1:0]  mk_sub;

    logic [SET_W-1:0]  pend_set;
    logic [WAY_W-1:0]  pend_way;
    logic [TAG_W-1:0]  pend_tag;
    logic [SUB_W-1:0]  pend_sub;
    logic              pend_write;

    cache_lru_order #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .upd_en(accept), .upd_set(set_i), .upd_way(use_way),
        .rd_set(set_i), .victim_way(victim), .order_flat(lru_flat)
    );

    cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .SUBS(SUBS), .TAG_W(TAG_W),
                      .DIRTY_EN(DIRTY_EN)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_set(set_i), .lk_tag(tag_i), .lk_sub(sub_i),
        .lk_match(lk_match), .lk_way(lk_way), .lk_present(lk_present),
        .rd_way(victim), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_dirty(rd_dirty),
        .al_en(full_miss), .al_way(victim),
        .mk_en(mk_en), .mk_set(mk_set), .mk_way(mk_way), .mk_sub(mk_sub),
        .mk_present(mk_present), .mk_dirty(mk_dirty)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CT_IDLE;
        else        state_q <= state_d;
    end

    // Next state, handshake outputs and flag updates
    always_comb begin
        state_d    = state_q;
        req_ready  = 1'b0;
        wb_req     = 1'b0;
        fill_req   = 1'b0;
        mk_en      = 1'b0;
        mk_set     = set_i;
        mk_way     = lk_way;
        mk_sub     = sub_i;
        mk_present = 1'b0;
        mk_dirty   = 1'b0;
        unique case (state_q)
            CT_IDLE: begin
                req_ready = 1'b1;
                if (full_miss)     state_d = victim_dirty ? CT_WBACK : CT_FILL;
                else if (sub_miss) state_d = CT_FILL;
                if (hit && req_write) begin
                    mk_en    = 1'b1;
                    mk_dirty = 1'b1;
                end
            end
            CT_WBACK: begin
                wb_req = 1'b1;
                if (wb_done) state_d = CT_FILL;
            end
            CT_FILL: begin
                fill_req = 1'b1;
                if (fill_done) begin
                    state_d    = CT_IDLE;
                    mk_en      = 1'b1;
                    mk_set     = pend_set;
                    mk_way     = pend_way;
                    mk_sub     = pend_sub;
                    mk_present = 1'b1;
                    mk_dirty   = pend_write;
                end
            end
            default: state_d = CT_IDLE;
        endcase
    end

    assign fill_addr = {pend_tag, pend_set, pend_sub, {OFS_W{1'b0}}};
    assign fill_way  = pend_way;

    // Response and pending-miss registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_tag_match <= 1'b0;
            rsp_way       <= '0;
            rsp_sub       <= '0;
            pend_set      <= '0;
            pend_way      <= '0;
            pend_tag      <= '0;
            pend_sub      <= '0;
            pend_write    <= 1'b0;
            wb_addr       <= '0;
            wb_mask       <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit       <= hit;
                rsp_tag_match <= lk_match;
                rsp_way       <= use_way;
                rsp_sub       <= sub_i;
                pend_set      <= set_i;
                pend_way      <= use_way;
                pend_tag      <= tag_i;
                pend_sub      <= sub_i;
                pend_write    <= req_write;
            end
            if (full_miss) begin
                wb_addr <= {rd_tag, set_i, {BLK_LO{1'b0}}};
                wb_mask <= rd_valid ? rd_dirty : '0;
            end
        end
    end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
`timescale 1ns/1ps
module cache_tag_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int SUBS   = 4,
    parameter int WAY_W  = $clog2(WAYS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       rsp_valid,
    input logic                       wb_req,
    input logic [ADDR_W-1:0]          wb_addr,
    input logic [SUBS-1:0]            wb_mask,
    input logic                       wb_done,
    input logic                       fill_req,
    input logic [ADDR_W-1:0]          fill_addr,
    input logic                       fill_done,
    input logic [SETS*WAYS*WAY_W-1:0] lru_flat
);
    function automatic logic perm_ok(input logic [WAYS*WAY_W-1:0] v);
        logic [WAYS-1:0] seen;
        seen = '0;
        for (int i = 0; i < WAYS; i++) seen[v[i*WAY_W +: WAY_W]] = 1'b1;
        return &seen;
    endfunction

    a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    a_r2_rsp_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));
    a_r6_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(wb_req || fill_req));
    a_r5_wb_fill_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && fill_req));
    a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> (wb_req && $stable(wb_addr) && $stable(wb_mask)));
    a_r5_wb_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_mask != '0));
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_done) |=> fill_req);
    a_r6_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_addr)));
    a_r6_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_done) |=> req_ready);

    for (genvar s = 0; s < SETS; s++) begin : g_perm
        a_r8_order_perm: assert property (@(posedge clk) disable iff (!rst_n)
            perm_ok(lru_flat[s*WAYS*WAY_W +: WAYS*WAY_W]));
    end
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .SUBS(SUBS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .wb_req(wb_req), .wb_addr(wb_addr), .wb_mask(wb_mask),
    .wb_done(wb_done), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_done(fill_done), .lru_flat(lru_flat)
);

// File: tb/sim_cache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_cache_tag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_tag_match;
    logic [1:0]  rsp_way, rsp_sub, fill_way;
    logic        wb_req, fill_req;
    logic [31:0] wb_addr, fill_addr;
    logic [3:0]  wb_mask;
    logic        wb_done = 1'b0;
    logic        fill_done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cache_tag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_tag_match(rsp_tag_match), .rsp_way(rsp_way),
        .rsp_sub(rsp_sub), .wb_req(wb_req), .wb_addr(wb_addr), .wb_mask(wb_mask),
        .wb_done(wb_done), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_way(fill_way), .fill_done(fill_done)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int unsigned m_tag [4][4];
    bit          m_vld [4][4];
    bit          m_pres[4][4][4];
    bit          m_dty [4][4][4];
    int          m_ord [4][$];
    int          m_state;      // 0 idle, 1 write-back, 2 fill
    bit          e_rv, e_hit, e_tm;
    int          e_way, e_sub;
    int unsigned e_wb_addr, e_fill_addr;
    int          e_wb_mask, e_fill_way;
    int          p_set, p_way, p_sub;
    int unsigned p_tag;
    bit          p_wr;

    function automatic void touch(int s, int w);
        foreach (m_ord[s][i]) if (m_ord[s][i] == w) begin
            m_ord[s].delete(i);
            break;
        end
        m_ord[s].push_front(w);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) begin
                m_ord[s] = {0, 1, 2, 3};
                for (int w = 0; w < 4; w++) begin
                    m_tag[s][w] = 0; m_vld[s][w] = 0;
                    for (int b = 0; b < 4; b++) begin m_pres[s][w][b] = 0; m_dty[s][w][b] = 0; end
                end
            end
            m_state = 0; e_rv = 0;
        end else begin
            e_rv = 0;
            case (m_state)
                0: if (req_valid) begin
                    int s, b, hw;
                    int unsigned t;
                    s = int'(req_addr[9:8]); b = int'(req_addr[7:6]); t = req_addr[31:10];
                    hw = -1;
                    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
                    e_rv = 1; e_sub = b;
                    p_set = s; p_sub = b; p_tag = t; p_wr = req_write;
                    if (hw >= 0 && m_pres[s][hw][b]) begin
                        e_hit = 1; e_tm = 1; e_way = hw;
                        if (req_write) m_dty[s][hw][b] = 1;
                    end else if (hw >= 0) begin
                        e_hit = 0; e_tm = 1; e_way = hw; m_state = 2;
                    end else begin
                        int v;
                        v = m_ord[s][3];
                        e_hit = 0; e_tm = 0; e_way = v;
                        e_wb_mask = 0;
                        for (int k = 0; k < 4; k++) if (m_vld[s][v] && m_dty[s][v][k]) e_wb_mask |= (1 << k);
                        e_wb_addr = (m_tag[s][v] << 10) | (s << 8);
                        m_tag[s][v] = t; m_vld[s][v] = 1;
                        for (int k = 0; k < 4; k++) begin m_pres[s][v][k] = 0; m_dty[s][v][k] = 0; end
                        m_state = (e_wb_mask != 0) ? 1 : 2;
                    end
                    p_way = e_way;
                    e_fill_addr = (p_tag << 10) | (p_set << 8) | (p_sub << 6);
                    e_fill_way = p_way;
                    touch(s, e_way);
                end
                1: if (wb_done) m_state = 2;
                2: if (fill_done) begin
                    m_pres[p_set][p_way][p_sub] = 1;
                    if (p_wr) m_dty[p_set][p_way][p_sub] = 1;
                    m_state = 0;
                end
                default: m_state = 0;
            endcase
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R6 req_ready", req_ready, m_state == 0);
            chk("R2 rsp_valid", rsp_valid, e_rv);
            if (e_rv) begin
                string k;
                k = e_hit ? "R2" : (e_tm ? "R3" : "R4/R8");
                chk({k, " rsp_hit"}, rsp_hit, e_hit);
                chk({k, " rsp_tag_match"}, rsp_tag_match, e_tm);
                chk({k, " rsp_way"}, rsp_way, e_way);
                chk("R2 rsp_sub", rsp_sub, e_sub);
            end
            chk("R5 wb_req", wb_req, m_state == 1);
            if (m_state == 1) begin
                chk("R5 wb_addr", wb_addr, e_wb_addr);
                chk("R5/R7 wb_mask", wb_mask, e_wb_mask);
            end
            chk("R6 fill_req", fill_req, m_state == 2);
            if (m_state == 2) begin
                chk("R3/R6 fill_addr", fill_addr, e_fill_addr);
                chk("R3/R6 fill_way", fill_way, e_fill_way);
            end
        end
    end

    // Responder for write-back and fill handshakes
    initial begin
        int wc, fc;
        wc = 0; fc = 0;
        forever begin
            @(negedge clk);
            wb_done = 0; fill_done = 0;
            if (wb_req) begin wc++; if (wc >= 2) begin wb_done = 1; wc = 0; end end else wc = 0;
            if (fill_req) begin fc++; if (fc >= 3) begin fill_done = 1; fc = 0; end end else fc = 0;
        end
    end

    function automatic logic [31:0] mk(int t, int s, int b, int wd);
        return 32'((t << 10) | (s << 8) | (b << 6) | (wd << 2));
    endfunction

    task automatic do_req(input logic [31:0] a, input bit wr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no response", rsp_valid, 0);
        chk("R1 no write-back", wb_req, 0);
        chk("R1 no fill", fill_req, 0);

        do_req(mk(5, 0, 1, 3), 0);
        chk("R1 first victim is way 3", rsp_way, 3);
        chk("R4 full miss no tag match", rsp_tag_match, 0);
        do_req(mk(5, 0, 1, 0), 0);
        chk("R2 hit after fill", rsp_hit, 1);
        do_req(mk(5, 0, 2, 0), 0);
        chk("R3 sub-block miss tag match", rsp_tag_match, 1);
        chk("R3 sub-block miss way", rsp_way, 3);
        do_req(mk(5, 0, 1, 7), 0);
        chk("R3 other sub-block still present", rsp_hit, 1);
        do_req(mk(5, 0, 2, 0), 1);
        chk("R7 write hit", rsp_hit, 1);
        do_req(mk(6, 0, 0, 0), 0); chk("R8 victim way 2", rsp_way, 2);
        do_req(mk(7, 0, 0, 0), 0); chk("R8 victim way 1", rsp_way, 1);
        do_req(mk(8, 0, 0, 0), 0); chk("R8 victim way 0", rsp_way, 0);
        do_req(mk(5, 0, 1, 0), 0);
        do_req(mk(9, 0, 3, 0), 0);  chk("R8 victim after reorder", rsp_way, 2);
        do_req(mk(10, 0, 0, 0), 0); chk("R8 next victim", rsp_way, 1);
        do_req(mk(1, 1, 0, 0), 0);  chk("R9 other set untouched", rsp_way, 3);
        do_req(mk(11, 0, 0, 0), 0); chk("R8 victim way 0 again", rsp_way, 0);
        do_req(mk(12, 0, 0, 0), 0); chk("R5 dirty victim way 3", rsp_way, 3);
        @(negedge clk);
        chk("R5 write-back raised", wb_req, 1);
        chk("R7 dirty mask sub-block 2", wb_mask, 4'b0100);
        do_req(mk(3, 2, 1, 0), 1);
        do_req(mk(3, 2, 1, 0), 0);
        chk("R7 write fill then hit", rsp_hit, 1);

        for (int n = 0; n < 400; n++)
            do_req(mk($urandom_range(5), $urandom_range(3), $urandom_range(3),
                      $urandom_range(15)), 1'($urandom_range(1)));
        repeat (12) @(negedge clk);
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        done_flag = 1;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule